// File: doc/BRIEF.md
# Nibble-Loaded Double-Buffered Converter Register

This block is the digital front end of a 12-bit digital-to-analog converter that a microprocessor writes as if it were four RAM locations. The bus supplies a 4-bit data word, a 2-bit operation select, an active-low select and an active-low write strobe. Three staging registers each hold one 4-bit slice of the code. A fourth operation copies all three slices into the 12-bit output register in one step, so the converter never sees a half-written code.

The bus signals are sampled on a system clock. A write takes effect on the clock edge where the strobe is first seen high again. At that edge the block uses the select, operation and data values it sampled in the last cycle the strobe was low. A separate active-low clear zeroes the output register at once, without waiting for a clock. Clear leaves the staged slices untouched.

Top module: `dacfe_top`

## Requirements
- R1: While `rst_n` is low, `dac_code` is 0 and all three staged slices are 0. A transfer made right after reset therefore outputs 0.
- R2: `op_sel` selects the operation. 0 loads code bits [3:0], 1 loads bits [7:4], 2 loads bits [11:8], and 3 copies the staged slices to `dac_code`.
- R3: A write commits on the first rising clock edge at which `wr_n` is sampled 1 after having been sampled 0. It uses the `cs_n`, `op_sel` and `data_in` values sampled at the previous edge. A transfer's new code appears on `dac_code` right after that commit edge and not before it.
- R4: A write strobe whose last low sample had `cs_n` high changes neither a staged slice nor `dac_code`.
- R5: A slice load never changes `dac_code`.
- R6: A transfer loads all 12 bits of `dac_code` at the same edge, from {high, middle, low} slices.
- R7: Driving `clr_n` low forces `dac_code` to 0 immediately, with no clock edge needed.
- R8: Clear does not alter the staged slices. A transfer made after `clr_n` returns high outputs the previously staged code, including slices loaded while clear was low.
- R9: While `clr_n` is low, `dac_code` stays 0 even if a transfer commits. After release it stays 0 until the next transfer.
- R10: Slices may be loaded in any order. Each slice holds its last written value until it is written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset of the whole block |
| clr_n | input | 1 | Asynchronous active-low clear of the output register only |
| cs_n | input | 1 | Active-low device select, decoded from upper bus address |
| wr_n | input | 1 | Active-low write strobe; commit on its return high |
| op_sel | input | 2 | Operation: slice low/middle/high or transfer |
| data_in | input | 4 | Slice data |
| dac_code | output | 12 | Code presented to the converter |

## Verification
Slice and transfer results are due one edge after the strobe's low-to-high change is sampled. The bench therefore drives inputs on falling edges, and it compares `dac_code` with a behavioural model on every falling edge, half a cycle after each commit edge. For the timing of R3, the bench checks the output both in the half cycle before the commit edge and in the half cycle after it. The bench applies clear between clock edges and checks the output 2 ns later, with no clock edge between, to show the effect is immediate.

// File: rtl/dacfe_pkg.sv
`timescale 1ns/1ps
package dacfe_pkg;
    // default geometry: three 4-bit slices form a 12-bit code
    localparam int DEF_NIB_W   = 4;
    localparam int DEF_NIB_CNT = 3;

    // one sampled bus cycle
    typedef struct packed {
        logic       wr_n;
        logic       cs_n;
        logic [1:0] op;
        logic [3:0] data;
    } bus_smp_t;

    localparam bus_smp_t BUS_IDLE = '{wr_n: 1'b1, cs_n: 1'b1, op: 2'd0, data: 4'd0};
endpackage

// File: rtl/dacfe_bus_capture.sv
`timescale 1ns/1ps
module dacfe_bus_capture #(
    parameter int NIB_W = 4,
    parameter int OP_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             wr_n,
    input  logic [OP_W-1:0]  op_sel,
    input  logic [NIB_W-1:0] data_in,
    output logic             commit_en,
    output logic [OP_W-1:0]  commit_op,
    output logic [NIB_W-1:0] commit_data
);
    typedef struct packed {
        logic             wr_n;
        logic             cs_n;
        logic [OP_W-1:0]  op;
        logic [NIB_W-1:0] data;
    } smp_t;

    smp_t smp_d, smp_q;

    // next state: the current bus values, held for one cycle
    always_comb begin
        smp_d      = smp_q;
        smp_d.wr_n = wr_n;
        smp_d.cs_n = cs_n;
        smp_d.op   = op_sel;
        smp_d.data = data_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q.wr_n <= 1'b1;
            smp_q.cs_n <= 1'b1;
            smp_q.op   <= '0;
            smp_q.data <= '0;
        end else begin
            smp_q <= smp_d;
        end
    end

    // strobe returning high after a selected low sample
    always_comb begin
        commit_en   = wr_n & ~smp_q.wr_n & ~smp_q.cs_n;
        commit_op   = smp_q.op;
        commit_data = smp_q.data;
    end
endmodule

// File: rtl/dacfe_nibble_bank.sv
`timescale 1ns/1ps
module dacfe_nibble_bank #(
    parameter int NIB_W   = 4,
    parameter int NIB_CNT = 3,
    parameter int OP_W    = 2,
    localparam int CODE_W = NIB_W * NIB_CNT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_en,
    input  logic [OP_W-1:0]   commit_op,
    input  logic [NIB_W-1:0]  commit_data,
    output logic [CODE_W-1:0] staged
);
    logic [NIB_CNT-1:0][NIB_W-1:0] lane_d, lane_q;
    logic [NIB_CNT-1:0]            lane_hit;

    for (genvar g = 0; g < NIB_CNT; g++) begin : g_lane
        always_comb begin
            lane_hit[g] = commit_en && (commit_op == OP_W'(g));
            lane_d[g]   = lane_hit[g] ? commit_data : lane_q[g];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lane_q[g] <= '0;
            else        lane_q[g] <= lane_d[g];
        end
    end

    assign staged = lane_q;
endmodule

// File: rtl/dacfe_out_reg.sv
`timescale 1ns/1ps
module dacfe_out_reg #(
    parameter int CODE_W  = 12,
    parameter int OP_W    = 2,
    parameter int XFER_OP = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic              commit_en,
    input  logic [OP_W-1:0]   commit_op,
    input  logic [CODE_W-1:0] staged,
    output logic [CODE_W-1:0] dac_code
);
    logic [CODE_W-1:0] code_d, code_q;
    logic              zero_n;

    assign zero_n = rst_n & clr_n;

    always_comb begin
        code_d = code_q;
        if (commit_en && (commit_op == OP_W'(XFER_OP))) code_d = staged;
    end

    always_ff @(posedge clk or negedge zero_n) begin
        if (!zero_n) code_q <= '0;
        else         code_q <= code_d;
    end

    assign dac_code = code_q;
endmodule

// File: rtl/dacfe_top.sv
`timescale 1ns/1ps
module dacfe_top
    import dacfe_pkg::*;
#(
    parameter int NIB_W   = DEF_NIB_W,
    parameter int NIB_CNT = DEF_NIB_CNT,
    localparam int CODE_W  = NIB_W * NIB_CNT,
    localparam int OP_W    = $clog2(NIB_CNT + 1),
    localparam int XFER_OP = NIB_CNT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic [OP_W-1:0]   op_sel,
    input  logic [NIB_W-1:0]  data_in,
    output logic [CODE_W-1:0] dac_code
);
    logic              commit_en;
    logic [OP_W-1:0]   commit_op;
    logic [NIB_W-1:0]  commit_data;
    logic [CODE_W-1:0] staged_code;

    dacfe_bus_capture #(.NIB_W(NIB_W), .OP_W(OP_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n),
        .op_sel(op_sel), .data_in(data_in),
        .commit_en(commit_en), .commit_op(commit_op), .commit_data(commit_data)
    );

    dacfe_nibble_bank #(.NIB_W(NIB_W), .NIB_CNT(NIB_CNT), .OP_W(OP_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .commit_en(commit_en), .commit_op(commit_op),
        .commit_data(commit_data), .staged(staged_code)
    );

    dacfe_out_reg #(.CODE_W(CODE_W), .OP_W(OP_W), .XFER_OP(XFER_OP)) u_out (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .commit_en(commit_en),
        .commit_op(commit_op), .staged(staged_code), .dac_code(dac_code)
    );
endmodule

// File: rtl/dacfe_checker.sv
`timescale 1ns/1ps
module dacfe_checker #(
    parameter int CODE_W  = 12,
    parameter int OP_W    = 2,
    parameter int XFER_OP = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr_n,
    input logic [CODE_W-1:0] dac_code,
    input logic [CODE_W-1:0] staged,
    input logic              wr_pulse,
    input logic [OP_W-1:0]   wr_op
);
    // R1: output is zero whenever reset is held
    a_r1_reset_zero: assert property (@(posedge clk) !rst_n |-> dac_code == '0);

    // R5: a slice load leaves the output untouched
    a_r5_slice_isolated: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        (wr_pulse && wr_op != OP_W'(XFER_OP)) |=> $stable(dac_code));

    // R6: transfer copies all staged bits together
    a_r6_transfer_all: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        (wr_pulse && wr_op == OP_W'(XFER_OP)) |=> dac_code == $past(staged));

    // R7 / R9: clear held means zero output
    a_r9_clear_holds_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> dac_code == '0);

    // R4 / R10: staged slices change only on a commit
    a_r10_staged_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_pulse |=> $stable(staged));

    // R5: output moves only on a transfer or a clear
    a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        !(wr_pulse && wr_op == OP_W'(XFER_OP)) |=> $stable(dac_code));
endmodule

bind dacfe_top dacfe_checker #(.CODE_W(CODE_W), .OP_W(OP_W), .XFER_OP(XFER_OP)) u_chk (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .dac_code(dac_code),
    .staged(staged_code), .wr_pulse(commit_en), .wr_op(commit_op)
);

// File: tb/dacfe_top_test.sv
`timescale 1ns/1ps
module dacfe_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr_n = 1'b1;
    logic        cs_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [1:0]  op_sel = 2'd0;
    logic [3:0]  data_in = 4'd0;
    logic [11:0] dac_code;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    string cur_req = "R3";

    always #10 clk = ~clk;

    dacfe_top uut (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .cs_n(cs_n), .wr_n(wr_n),
        .op_sel(op_sel), .data_in(data_in), .dac_code(dac_code)
    );

    // behavioural reference model
    int ref_lat[3];
    int ref_dac = 0;
    bit p_wr = 1'b1, p_cs = 1'b1;
    int p_op = 0, p_dat = 0;

    initial begin
        ref_lat[0] = 0; ref_lat[1] = 0; ref_lat[2] = 0;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            ref_lat[0] = 0; ref_lat[1] = 0; ref_lat[2] = 0;
            ref_dac = 0; p_wr = 1'b1; p_cs = 1'b1;
        end else begin
            if (wr_n && !p_wr && !p_cs) begin
                if (p_op < 3) ref_lat[p_op] = p_dat;
                else if (clr_n) ref_dac = ref_lat[2] * 256 + ref_lat[1] * 16 + ref_lat[0];
            end
            p_wr = wr_n; p_cs = cs_n; p_op = int'(op_sel); p_dat = int'(data_in);
        end
        if (!clr_n) ref_dac = 0;
    end

    always @(negedge clr_n) ref_dac = 0;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (int'(dac_code) != ref_dac) begin
                failures++;
                $display("FAIL %s per-cycle model: dac_code=%03h expected=%03h", cur_req, dac_code, ref_dac[11:0]);
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%03h expected=%03h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] op, input logic [3:0] d, input logic sel_n);
        @(negedge clk);
        cs_n = sel_n; op_sel = op; data_in = d; wr_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b1; data_in = ~d;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1 reset
        repeat (3) @(negedge clk);
        check("R1", int'(dac_code), 0);
        rst_n = 1'b1;
        cur_req = "R1";
        bus_write(2'd3, 4'h0, 1'b0);
        check("R1", int'(dac_code), 0);

        // R2 / R5 / R6 fill low, middle, high then transfer
        cur_req = "R5";
        bus_write(2'd0, 4'hA, 1'b0);
        check("R5", int'(dac_code), 0);
        bus_write(2'd1, 4'h5, 1'b0);
        check("R5", int'(dac_code), 0);
        bus_write(2'd2, 4'hC, 1'b0);
        check("R5", int'(dac_code), 0);
        cur_req = "R6";
        bus_write(2'd3, 4'h0, 1'b0);
        check("R2", int'(dac_code), 'hC5A);

        // R10 reversed order
        cur_req = "R10";
        bus_write(2'd2, 4'h1, 1'b0);
        bus_write(2'd0, 4'h3, 1'b0);
        bus_write(2'd1, 4'h2, 1'b0);
        check("R5", int'(dac_code), 'hC5A);
        bus_write(2'd3, 4'h0, 1'b0);
        check("R10", int'(dac_code), 'h123);

        // R4 deselected writes
        cur_req = "R4";
        bus_write(2'd0, 4'hF, 1'b1);
        bus_write(2'd3, 4'h0, 1'b1);
        check("R4", int'(dac_code), 'h123);
        bus_write(2'd3, 4'h0, 1'b0);
        check("R4", int'(dac_code), 'h123);

        // R3 commit timing
        cur_req = "R3";
        bus_write(2'd1, 4'h7, 1'b0);
        @(negedge clk);
        cs_n = 1'b0; op_sel = 2'd3; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1; cs_n = 1'b1; op_sel = 2'd0;
        check("R3", int'(dac_code), 'h123);
        @(negedge clk);
        check("R3", int'(dac_code), 'h173);

        // R7 asynchronous clear between edges
        cur_req = "R7";
        @(posedge clk);
        #5 clr_n = 1'b0;
        #2 check("R7", int'(dac_code), 0);

        // R9 transfer during clear, R8 slice loaded during clear
        cur_req = "R9";
        bus_write(2'd3, 4'h0, 1'b0);
        check("R9", int'(dac_code), 0);
        bus_write(2'd0, 4'h9, 1'b0);
        check("R9", int'(dac_code), 0);
        @(negedge clk);
        clr_n = 1'b1;
        @(negedge clk);
        check("R9", int'(dac_code), 0);
        cur_req = "R8";
        bus_write(2'd3, 4'h0, 1'b0);
        check("R8", int'(dac_code), 'h179);

        // R10 last write wins
        cur_req = "R10";
        bus_write(2'd0, 4'h4, 1'b0);
        bus_write(2'd0, 4'h6, 1'b0);
        bus_write(2'd3, 4'h0, 1'b0);
        check("R10", int'(dac_code), 'h176);

        // R6 sweep of uniform codes
        cur_req = "R6";
        for (int v = 0; v < 16; v++) begin
            bus_write(2'd0, 4'(v), 1'b0);
            bus_write(2'd1, 4'(v), 1'b0);
            bus_write(2'd2, 4'(v), 1'b0);
            bus_write(2'd3, 4'h0, 1'b0);
            check("R6", int'(dac_code), v * 'h111);
        end

        // R1 reset mid-run clears everything
        cur_req = "R1";
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", int'(dac_code), 0);
        rst_n = 1'b1;
        bus_write(2'd3, 4'h0, 1'b0);
        check("R1", int'(dac_code), 0);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule